// File: doc/BRIEF.md
# Word-Strided Serial Port Register Front-End

This block is the processor-facing register file of a 16550-style serial port. Registers sit on 32-bit word boundaries, and a simple request bus reaches them. Each request carries an address, a write flag, write data, and an access size in bytes. One request may cover several consecutive registers. The block holds the line-control, interrupt-enable and scratch registers and a 16-bit baud divisor. The divisor shares the two lowest register slots with the data and interrupt-enable registers. Bit 7 of the line-control register selects which of the two the slots reach.

The block contains no serialiser, receiver, FIFO, interrupt logic or modem logic. A write to the transmit slot turns into a one-cycle character strobe on a byte-wide output. Status and receive registers read back as zero. A request that is not word-aligned, or whose size is not a whole number of words, is dropped. The 16-bit divisor is driven out so that a baud generator outside the block can use it.

Top module: `uart_reg_front`

## Requirements
- R1: The register slots sit at word offsets 0x00 (data), 0x04 (interrupt enable), 0x08 (interrupt ID), 0x0C (line control), 0x10 (modem control), 0x14 (line status), 0x18 (modem status) and 0x1C (scratch). Line control, interrupt enable and scratch are 32 bits wide and read back the last value written to them.
- R2: Only address bits [15:0] select a slot. Higher address bits have no effect.
- R3: Bit 7 of line control is the divisor-access bit. Every line-control write updates it. While the bit is set, offset 0x00 reaches the divisor low byte and offset 0x04 the divisor high byte. Each of these takes write bits [7:0] and reads back zero-extended. The `divisor` output is {high, low}. While the bit is clear, those offsets reach the data and interrupt-enable registers, and the divisor keeps its value.
- R4: A write to offset 0x00 with the divisor-access bit clear raises `tx_valid` for exactly one cycle, in the cycle after the request. `tx_data` carries write bits [7:0]. No other write raises `tx_valid`.
- R5: `tx_newline` is high together with `tx_valid` exactly when the emitted byte is 0x0A.
- R6: A read of offset 0x00 with the divisor-access bit clear returns zero.
- R7: The interrupt-ID, modem-control, line-status and modem-status slots, and every unmapped offset, read as zero and ignore writes.
- R8: A request is dropped if address bits [1:0] are not zero, or if the size is not a multiple of 4, or if the size exceeds 4*MAX_WORDS. A dropped read returns all zeros. A dropped write changes no register and emits no character.
- R9: An access of N words touches slots at offset, offset+4, and onward. Word i uses data bits [32i+31:32i]. Words beyond N read as zero, and a size of 0 touches nothing. An offset that steps past 0xFFFC does not wrap: it is unmapped.
- R10: The divisor-access bit in force for the whole access is the value held before the access.
- R11: A synchronous active-high reset clears every register, the divisor and the divisor-access bit. It also clears `rsp_valid` and `tx_valid`.
- R12: A read request gives `rsp_valid` high in the next cycle, with `rsp_rdata` carrying the read words. In every other cycle `rsp_valid` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [15:0] decode |
| req_size | input | SIZE_W | Access size in bytes |
| req_wdata | input | 32*MAX_WORDS | Write words, word 0 in the low bits |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32*MAX_WORDS | Registered read words |
| tx_valid | output | 1 | One-cycle character strobe |
| tx_data | output | 8 | Emitted character |
| tx_newline | output | 1 | Emitted character is 0x0A |
| divisor | output | 16 | Baud divisor {high, low} |

## Verification
The hardest case to reach is a multi-word access whose offset runs past the end of the 16-bit window while the divisor bank is switched in. A wrong design would wrap the offset to zero and return the divisor low byte instead of zero. The bench first sets the divisor-access bit and loads a nonzero divisor. It then reads two words from offset 0xFFFC, so an aliased wrap would show up as a nonzero upper word. Dropped writes are checked through a later read of the scratch register. Dropped writes are also checked through the divisor output and the character strobe.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam int WORD_W   = 32;
  localparam int NREG     = 8;
  localparam int OFF_W    = 17;  // 16-bit window plus one carry bit

  typedef enum logic [2:0] {
    SLOT_DATA = 3'd0,
    SLOT_IER  = 3'd1,
    SLOT_IID  = 3'd2,
    SLOT_LCR  = 3'd3,
    SLOT_MCR  = 3'd4,
    SLOT_LSR  = 3'd5,
    SLOT_MSR  = 3'd6,
    SLOT_SCR  = 3'd7
  } slot_e;

  localparam int DLAB_BIT = 7;

  // One-hot slot select for a word offset; zero when unmapped.
  function automatic logic [NREG-1:0] slot_onehot(input logic [OFF_W-1:0] off);
    logic [NREG-1:0] sel;
    sel = '0;
    if (off[OFF_W-1:5] == '0 && off[1:0] == 2'b00)
      sel[off[4:2]] = 1'b1;
    return sel;
  endfunction

endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
  import uart_fe_pkg::*;
#(
  parameter int SIZE_W    = 4,
  parameter int MAX_WORDS = 2
) (
  input  logic [15:0]                  addr_lo,
  input  logic [1:0]                   addr_align,
  input  logic [SIZE_W-1:0]            req_size,
  input  logic [WORD_W*MAX_WORDS-1:0]  req_wdata,
  output logic                         access_ok,
  output logic [MAX_WORDS-1:0][NREG-1:0] lane_sel,
  output logic [NREG-1:0]              reg_hit,
  output logic [NREG-1:0][WORD_W-1:0]  reg_wdata
);

  localparam int MAX_BYTES = 4 * MAX_WORDS;

  logic              size_ok;
  logic [SIZE_W-1:0] nwords;

  assign size_ok   = (req_size[1:0] == 2'b00) && (req_size <= SIZE_W'(MAX_BYTES));
  assign access_ok = size_ok && (addr_align == 2'b00);
  assign nwords    = req_size >> 2;

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_lane
    logic [OFF_W-1:0] off;
    logic             lane_on;
    assign off     = {1'b0, addr_lo} + OFF_W'(4 * g);
    assign lane_on = access_ok && (SIZE_W'(g) < nwords);
    assign lane_sel[g] = lane_on ? slot_onehot(off) : '0;
  end

  // Offsets of distinct lanes differ, so at most one lane hits each slot.
  always_comb begin
    reg_hit   = '0;
    reg_wdata = '0;
    for (int r = 0; r < NREG; r++) begin
      for (int l = 0; l < MAX_WORDS; l++) begin
        if (lane_sel[l][r]) begin
          reg_hit[r]   = 1'b1;
          reg_wdata[r] = reg_wdata[r] | req_wdata[l*WORD_W +: WORD_W];
        end
      end
    end
  end

endmodule

// File: rtl/uart_fe_reg_bank.sv
module uart_fe_reg_bank
  import uart_fe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [NREG-1:0]             reg_hit,
  input  logic [NREG-1:0][WORD_W-1:0] reg_wdata,
  output logic [NREG-1:0][WORD_W-1:0] rd_view,
  output logic [2*BYTE_W-1:0]         divisor,
  output logic                        tx_fire,
  output logic [BYTE_W-1:0]           tx_byte
);

  logic [WORD_W-1:0] lcr_q, ier_q, scr_q;
  logic [BYTE_W-1:0] div_lo_q, div_hi_q;
  logic              dlab;

  assign dlab = lcr_q[DLAB_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q    <= '0;
      ier_q    <= '0;
      scr_q    <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else if (wr_en) begin
      if (reg_hit[SLOT_DATA] && dlab) div_lo_q <= reg_wdata[SLOT_DATA][BYTE_W-1:0];
      if (reg_hit[SLOT_IER]) begin
        if (dlab) div_hi_q <= reg_wdata[SLOT_IER][BYTE_W-1:0];
        else      ier_q    <= reg_wdata[SLOT_IER];
      end
      if (reg_hit[SLOT_LCR]) lcr_q <= reg_wdata[SLOT_LCR];
      if (reg_hit[SLOT_SCR]) scr_q <= reg_wdata[SLOT_SCR];
    end
  end

  assign tx_fire = wr_en && reg_hit[SLOT_DATA] && !dlab;
  assign tx_byte = reg_wdata[SLOT_DATA][BYTE_W-1:0];
  assign divisor = {div_hi_q, div_lo_q};

  always_comb begin
    rd_view           = '0;
    rd_view[SLOT_DATA] = dlab ? WORD_W'(div_lo_q) : '0;
    rd_view[SLOT_IER]  = dlab ? WORD_W'(div_hi_q) : ier_q;
    rd_view[SLOT_LCR]  = lcr_q;
    rd_view[SLOT_SCR]  = scr_q;
  end

  // Writes to stub slots are dropped on purpose.
  logic unused_stub;
  assign unused_stub = ^{reg_hit[SLOT_IID], reg_hit[SLOT_MCR], reg_hit[SLOT_LSR],
                         reg_hit[SLOT_MSR], reg_wdata[SLOT_IID], reg_wdata[SLOT_MCR],
                         reg_wdata[SLOT_LSR], reg_wdata[SLOT_MSR]};

  // R11: registers leave reset cleared
  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lcr_q == '0 && ier_q == '0 && scr_q == '0 && divisor == '0));

  // R3: divisor only moves while the access bit was set
  assert_div_banked_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(dlab) && !$past(rst) |-> $stable(divisor));

endmodule

// File: rtl/uart_fe_tx_emit.sv
module uart_fe_tx_emit #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] NL_CODE = BYTE_W'(8'h0A)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_newline
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      tx_newline <= 1'b0;
    end else begin
      tx_valid   <= fire;
      tx_data    <= fire ? byte_in : '0;
      tx_newline <= fire && (byte_in == NL_CODE);
    end
  end

endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int MAX_WORDS = 2,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = WORD_W * MAX_WORDS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                tx_valid,
  output logic [BYTE_W-1:0]   tx_data,
  output logic                tx_newline,
  output logic [2*BYTE_W-1:0] divisor
);

  logic                          access_ok;
  logic [MAX_WORDS-1:0][NREG-1:0] lane_sel;
  logic [NREG-1:0]               reg_hit;
  logic [NREG-1:0][WORD_W-1:0]   reg_wdata;
  logic [NREG-1:0][WORD_W-1:0]   rd_view;
  logic                          wr_en;
  logic                          tx_fire;
  logic [BYTE_W-1:0]             tx_byte;
  logic [DATA_W-1:0]             rd_bus;

  logic unused_addr_hi;
  assign unused_addr_hi = ^req_addr[ADDR_W-1:16];

  uart_fe_decode #(.SIZE_W(SIZE_W), .MAX_WORDS(MAX_WORDS)) u_decode (
    .addr_lo   (req_addr[15:0]),
    .addr_align(req_addr[1:0]),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .access_ok (access_ok),
    .lane_sel  (lane_sel),
    .reg_hit   (reg_hit),
    .reg_wdata (reg_wdata)
  );

  assign wr_en = req_valid && req_write && access_ok;

  uart_fe_reg_bank #(.BYTE_W(BYTE_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .reg_hit  (reg_hit),
    .reg_wdata(reg_wdata),
    .rd_view  (rd_view),
    .divisor  (divisor),
    .tx_fire  (tx_fire),
    .tx_byte  (tx_byte)
  );

  uart_fe_tx_emit #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .fire      (tx_fire),
    .byte_in   (tx_byte),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_newline(tx_newline)
  );

  // Read mux: each lane picks the slot its offset selected.
  always_comb begin
    rd_bus = '0;
    for (int l = 0; l < MAX_WORDS; l++) begin
      for (int r = 0; r < NREG; r++) begin
        if (lane_sel[l][r])
          rd_bus[l*WORD_W +: WORD_W] = rd_bus[l*WORD_W +: WORD_W] | rd_view[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_bus : '0;
    end
  end

  // R4: a character strobe follows only an aligned write request
  assert_tx_from_write_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(req_valid && req_write && req_addr[1:0] == 2'b00));

  // R5: newline flag accompanies a 0x0A strobe only
  assert_newline_flag_R5: assert property (@(posedge clk) disable iff (rst)
    tx_newline |-> (tx_valid && tx_data == BYTE_W'(8'h0A)));

  // R12: response follows a read request by one cycle
  assert_rsp_follows_read_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  // R8: misaligned read returns zeros
  assert_misaligned_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr[1:0] != 2'b00)) |-> rsp_rdata == '0);

  // R8: a dropped write leaves the divisor and strobe quiet
  assert_dropped_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !access_ok) |=> ($stable(divisor) && !tx_valid));

endmodule

// File: tb/test_uart_reg_front.sv
module test_uart_reg_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr  = '0;
  logic [3:0]  req_size  = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_newline;
  logic [15:0] divisor;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  uart_reg_front i_uart_reg_front (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_newline(tx_newline), .divisor(divisor)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  size;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic        txv;
    logic [7:0]  txd;
    logic        txnl;
    logic [15:0] div;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h1C, 4'd4, 64'hDEADBEEF, 64'h0, 1'b0, 8'h00, 1'b0, 16'h0000}, // R1 scratch
    '{1'b0, 32'h1C, 4'd4, 64'h0, 64'hDEADBEEF, 1'b0, 8'h00, 1'b0, 16'h0000},
    '{1'b1, 32'h0C, 4'd4, 64'h03, 64'h0, 1'b0, 8'h00, 1'b0, 16'h0000},       // R1 line ctrl
    '{1'b0, 32'h0C, 4'd4, 64'h0, 64'h03, 1'b0, 8'h00, 1'b0, 16'h0000},
    '{1'b1, 32'h04, 4'd4, 64'h5A, 64'h0, 1'b0, 8'h00, 1'b0, 16'h0000},       // R4 IER: no strobe
    '{1'b0, 32'h04, 4'd4, 64'h0, 64'h5A, 1'b0, 8'h00, 1'b0, 16'h0000},
    '{1'b1, 32'h00, 4'd4, 64'h141, 64'h0, 1'b1, 8'h41, 1'b0, 16'h0000},      // R4 emit
    '{1'b0, 32'h00, 4'd4, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'h0000},        // R6
    '{1'b1, 32'h0C, 4'd4, 64'h83, 64'h0, 1'b0, 8'h00, 1'b0, 16'h0000},       // R3 bank on
    '{1'b1, 32'h00, 4'd4, 64'h1234, 64'h0, 1'b0, 8'h00, 1'b0, 16'h0034},     // R3 div low
    '{1'b1, 32'h04, 4'd4, 64'hAB, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},       // R3 div high
    '{1'b0, 32'h00, 4'd8, 64'h0, 64'h000000AB_00000034, 1'b0, 8'h00, 1'b0, 16'hAB34}, // R9
    '{1'b1, 32'h0C, 4'd4, 64'h03, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b0, 32'h04, 4'd4, 64'h0, 64'h5A, 1'b0, 8'h00, 1'b0, 16'hAB34},       // R3 IER kept
    '{1'b1, 32'hABCD001C, 4'd4, 64'h77, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34}, // R2
    '{1'b0, 32'h0000001C, 4'd4, 64'h0, 64'h77, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b1, 32'h18, 4'd8, 64'h00000099_FFFFFFFF, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34}, // R9
    '{1'b0, 32'h18, 4'd8, 64'h0, 64'h00000099_00000000, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b1, 32'h1D, 4'd4, 64'h11, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},       // R8 misaligned
    '{1'b1, 32'h1C, 4'd2, 64'h22, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},       // R8 partial
    '{1'b1, 32'h1C, 4'd12, 64'h33, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},      // R8 too large
    '{1'b0, 32'h1C, 4'd4, 64'h0, 64'h99, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b0, 32'h1D, 4'd4, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},        // R8 read
    '{1'b0, 32'h1C, 4'd2, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b1, 32'h00, 4'd6, 64'h41, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},       // R8 no strobe
    '{1'b1, 32'h10, 4'd8, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34}, // R7
    '{1'b0, 32'h10, 4'd8, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b1, 32'h08, 4'd4, 64'hFF, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b0, 32'h08, 4'd4, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b1, 32'h00, 4'd4, 64'h0A, 64'h0, 1'b1, 8'h0A, 1'b1, 16'hAB34},       // R5 newline
    '{1'b1, 32'h3C, 4'd4, 64'h55, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},       // R7 unmapped
    '{1'b0, 32'h3C, 4'd4, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b0, 32'h1C, 4'd0, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},        // R9 size 0
    '{1'b1, 32'h0C, 4'd4, 64'h83, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},
    '{1'b0, 32'hFFFC, 4'd8, 64'h0, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34},      // R9 no wrap
    '{1'b1, 32'h08, 4'd8, 64'h00000003_00000000, 64'h0, 1'b0, 8'h00, 1'b0, 16'hAB34} // R10
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge, outputs settled.
  task automatic run(input logic wr, input logic [31:0] a, input logic [3:0] s,
                     input logic [63:0] wd);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R11 tx_valid", 64'(tx_valid), 64'h0);
    chk("R11 divisor", 64'(divisor), 64'h0);
    chk("R12 idle rdata", rsp_rdata, 64'h0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
      chk($sformatf("R12 rsp_valid v%0d", i), 64'(rsp_valid), 64'(!VECS[i].wr));
      chk($sformatf("R1/R9 rdata v%0d", i), rsp_rdata, VECS[i].rdata);
      chk($sformatf("R4 tx_valid v%0d", i), 64'(tx_valid), 64'(VECS[i].txv));
      chk($sformatf("R4 tx_data v%0d", i), 64'(tx_data), 64'(VECS[i].txd));
      chk($sformatf("R5 tx_newline v%0d", i), 64'(tx_newline), 64'(VECS[i].txnl));
      chk($sformatf("R3 divisor v%0d", i), 64'(divisor), 64'(VECS[i].div));
    end

    // R10: the last vector wrote line control 0x03 at offset 0x0C
    run(1'b0, 32'h0C, 4'd4, 64'h0);
    chk("R10 lcr after multi-word", rsp_rdata, 64'h3);
    // R4: strobe is one cycle wide
    run(1'b1, 32'h00, 4'd4, 64'h21);
    chk("R4 strobe", 64'({tx_valid, tx_data}), 64'h121);
    @(negedge clk);
    chk("R4 single cycle", 64'(tx_valid), 64'h0);

    // R11 reset mid-run clears state and the access bit
    run(1'b1, 32'h0C, 4'd4, 64'h80);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R11 divisor cleared", 64'(divisor), 64'h0);
    run(1'b0, 32'h1C, 4'd4, 64'h0);
    chk("R11 scratch cleared", rsp_rdata, 64'h0);
    run(1'b0, 32'h0C, 4'd8, 64'h0);
    chk("R11 lcr cleared", rsp_rdata, 64'h0);
    run(1'b1, 32'h00, 4'd4, 64'h42);
    chk("R11 access bit cleared", 64'({tx_valid, tx_data}), 64'h142);
    chk("R3 divisor untouched", 64'(divisor), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule